// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on the two-wire Ethernet PHY management bus. A host pulses a start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The master derives the management clock from the system clock with a parameterised divider and serialises the whole frame. For reads it captures the returned 16-bit value.

Every frame opens with a long all-ones preamble, so PHYs that need one after power-up or after a bus fault always get it. On a read the master releases the data line for the turnaround and then checks that the PHY pulled it low. If the PHY did not respond, the master clocks out a fixed run of idle cycles to let the PHY recover, and reports an error in place of data. The data line is modelled as separate output, output-enable and input signals. An external pull-up holds the line high whenever nobody drives it.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is running, `mdc` is low, `mdio_oe` is low, `busy` is low and `done` is low.
- R2: A frame starts with 32 bit slots in which `mdio_oe` is high and `mdio_out` is 1. A bit slot is one `mdc` period: a low half followed by a high half.
- R3: After the preamble the master drives the start pattern 0 then 1, then the operation code. The code is 1 then 0 for a read (`rd_sel`=1) and 0 then 1 for a write (`rd_sel`=0).
- R4: Slots 36 to 40 carry `phy_addr` and slots 41 to 45 carry `reg_addr`, each most significant bit first.
- R5: Each half of an `mdc` period lasts exactly HALF_CYC system clocks. `mdio_out` and `mdio_oe` change only as `mdc` goes low, and they stay stable while `mdc` is high.
- R6: On a read, `mdio_oe` is low from slot 46 until the frame ends. `mdio_in` is sampled at the end of the high half of slot 47, and that bit must be 0.
- R7: If the slot-47 sample is 1, the master runs 32 further released slots (48 to 79). It then ends the frame with `ta_err`=1 and `rdata`=0.
- R8: On a good read, slots 48 to 63 are sampled at the end of their high halves into `rdata`, most significant bit first. One trailing released slot (64) follows, and the frame ends with `ta_err`=0.
- R9: On a write, slots 46 and 47 drive 1 then 0, and slots 48 to 63 drive `wdata` most significant bit first. Slot 64 is released.
- R10: `start` is acted on only while `busy` is low. The address, select and data inputs are latched when the strobe is accepted. `busy` rises on the clock edge that accepts the strobe and falls in the cycle in which `done` is high.
- R11: `done` is a single-cycle pulse. It is raised in the clock cycle right after the end of the last slot, which gives 65 slots for writes and good reads and 80 slots for a failed read. `rdata` and `ta_err` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transaction request strobe |
| rd_sel | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Write value |
| rdata | output | 16 | Captured read value |
| done | output | 1 | End-of-transaction pulse |
| busy | output | 1 | Transaction in progress |
| ta_err | output | 1 | PHY did not drive the turnaround low |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Sampled data line |

## Verification
The hardest path to reach is the recovery run after a missing turnaround. It needs a PHY model that stays silent exactly in slot 47 while the line floats high through the pull-up. The bench plays the PHY itself, and it drives `mdio_in` slot by slot from its own timing model. In one read it leaves the turnaround high, and the 32 extra released slots and the error result are then compared cycle by cycle. Two more frames pulse `start` mid-frame and scramble every host input right after acceptance, which shows that the running waveform does not change.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int HDR_LEN  = PRE_LEN + 4 + 2 * ADDR_W;   // driven in both directions
    localparam int FRAME_W  = HDR_LEN + 2 + DATA_W;       // full write frame
    localparam int TA_SLOT  = HDR_LEN + 1;                // turnaround sample slot
    localparam int OK_LAST  = FRAME_W;                    // trailing released slot
    localparam int ERR_LAST = TA_SLOT + PRE_LEN;          // end of recovery run
    localparam int SLOT_W   = $clog2(ERR_LAST + 1);

    typedef struct packed {
        logic               busy;
        logic               mdc;
        logic               oe;
        logic               done;
        logic               err;
        logic               rd;
        logic [SLOT_W-1:0]  slot;
        logic [FRAME_W-1:0] frame;
        logic [DATA_W-1:0]  rdata;
    } mst_state_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic half_end
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign half_end = en && (cnt_q == CNT_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || half_end) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_master_pkg::*;
(
    input  logic              rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] data,
    output logic [FRAME_W-1:0] frame
);
    logic [1:0] opcode;
    assign opcode = rd ? 2'b10 : 2'b01;
    assign frame  = {{PRE_LEN{1'b1}}, 2'b01, opcode, phy, regad, 2'b10, data};
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int HALF_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              ta_err,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam logic [SLOT_W-1:0] TA_S   = SLOT_W'(TA_SLOT);
    localparam logic [SLOT_W-1:0] OK_S   = SLOT_W'(OK_LAST);
    localparam logic [SLOT_W-1:0] ERR_S  = SLOT_W'(ERR_LAST);
    localparam logic [SLOT_W-1:0] HDR_S  = SLOT_W'(HDR_LEN);
    localparam logic [SLOT_W-1:0] FRM_S  = SLOT_W'(FRAME_W);
    localparam logic [SLOT_W-1:0] DLST_S = SLOT_W'(TA_SLOT + DATA_W);

    mst_state_t d, q;
    logic               half_end;
    logic [FRAME_W-1:0] frame_new;
    logic [SLOT_W-1:0]  last_slot;
    logic [SLOT_W-1:0]  next_slot;

    mdio_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.busy),
        .half_end (half_end)
    );

    mdio_frame_build u_build (
        .rd    (rd_sel),
        .phy   (phy_addr),
        .regad (reg_addr),
        .data  (wdata),
        .frame (frame_new)
    );

    assign last_slot = (q.rd && q.err) ? ERR_S : OK_S;
    assign next_slot = q.slot + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.mdc   = 1'b0;
                d.oe    = 1'b1;
                d.rd    = rd_sel;
                d.err   = 1'b0;
                d.slot  = '0;
                d.frame = frame_new;
                d.rdata = '0;
            end
        end else if (half_end) begin
            if (!q.mdc) begin
                d.mdc = 1'b1;
            end else begin
                d.mdc = 1'b0;
                if (q.rd && q.slot == TA_S && mdio_in)
                    d.err = 1'b1;
                if (q.rd && !q.err && q.slot > TA_S && q.slot <= DLST_S)
                    d.rdata = {q.rdata[DATA_W-2:0], mdio_in};
                if (q.slot == last_slot) begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.oe    = 1'b0;
                    d.frame = '0;
                end else begin
                    d.slot  = next_slot;
                    d.frame = q.frame << 1;
                    d.oe    = q.rd ? (next_slot < HDR_S) : (next_slot < FRM_S);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata    = q.rdata;
    assign done     = q.done;
    assign busy     = q.busy;
    assign ta_err   = q.err;
    assign mdc      = q.mdc;
    assign mdio_oe  = q.oe;
    assign mdio_out = q.oe & q.frame[FRAME_W-1];
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_master_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ta_err,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] rdata
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R1

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R5

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ta_err) |-> (rdata == '0)); // R7

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R10

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ta_err   (ta_err),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rdata    (rdata)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int H = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_sel = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        mdio_in = 1'b1;
    logic [15:0] rdata;
    logic        done, busy, ta_err, mdc, mdio_out, mdio_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_CYC(H)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .rdata(rdata), .done(done), .busy(busy), .ta_err(ta_err),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string region(input int s, input bit rd, input bit bad);
        if (s < 32)  return "R2";
        if (s < 36)  return "R3";
        if (s < 46)  return "R4";
        if (!rd)     return "R9";
        if (s < 48)  return "R6";
        if (bad)     return "R7";
        return "R8";
    endfunction

    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input bit bad, input bit disturb);
        bit exp_oe[$];
        bit exp_v[$];
        int last, total, s;
        for (int i = 0; i < 32; i++) begin exp_oe.push_back(1); exp_v.push_back(1); end
        exp_oe.push_back(1); exp_v.push_back(0);
        exp_oe.push_back(1); exp_v.push_back(1);
        exp_oe.push_back(1); exp_v.push_back(rd);
        exp_oe.push_back(1); exp_v.push_back(!rd);
        for (int i = 4; i >= 0; i--) begin exp_oe.push_back(1); exp_v.push_back(pa[i]); end
        for (int i = 4; i >= 0; i--) begin exp_oe.push_back(1); exp_v.push_back(ra[i]); end
        if (!rd) begin
            exp_oe.push_back(1); exp_v.push_back(1);
            exp_oe.push_back(1); exp_v.push_back(0);
            for (int i = 15; i >= 0; i--) begin exp_oe.push_back(1); exp_v.push_back(wd[i]); end
        end
        last  = (rd && bad) ? 79 : 64;
        while (exp_oe.size() < last + 1) begin exp_oe.push_back(0); exp_v.push_back(0); end
        total = 2 * H * (last + 1);

        @(negedge clk);
        rd_sel = rd; phy_addr = pa; reg_addr = ra; wdata = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: scrambled inputs after acceptance must not alter the frame
        rd_sel = !rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
        for (int t = 0; t <= total; t++) begin
            s = t / (2 * H);
            if (t < total) begin
                if (exp_oe[s])                       mdio_in = 1'b1;
                else if (rd && s == 47)              mdio_in = bad;
                else if (rd && !bad && s >= 48 && s <= 63) mdio_in = rv[63 - s];
                else                                 mdio_in = 1'b1;
                check(busy === 1'b1 && done === 1'b0, "R10", "busy/done in frame",
                      {busy, done}, 2'b10);
                check(mdc === ((t % (2 * H)) >= H), "R5", "mdc phase", mdc, ((t % (2 * H)) >= H));
                check(mdio_oe === exp_oe[s] && (!exp_oe[s] || mdio_out === exp_v[s]),
                      region(s, rd, bad), "mdio oe/out",
                      {mdio_oe, mdio_out}, {exp_oe[s], exp_v[s]});
                start = (disturb && t == 2 * H * 10 + 5);   // R10: ignored while busy
            end else begin
                check(done === 1'b1 && busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
                      "R11", "end of frame", {done, busy, mdc, mdio_oe}, 4'b1000);
                if (rd) begin
                    check(ta_err === bad, bad ? "R7" : "R6", "ta_err", ta_err, bad);
                    check(rdata === (bad ? 16'h0 : rv), bad ? "R7" : "R8", "rdata",
                          rdata, bad ? 16'h0 : rv);
                end
            end
            @(negedge clk);
        end
        check(done === 1'b0 && busy === 1'b0, "R11", "done single pulse", {done, busy}, 2'b00);
        if (rd)
            check(rdata === (bad ? 16'h0 : rv), "R11", "rdata held", rdata, bad ? 16'h0 : rv);
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done, "R1", "idle gap",
              {mdc, mdio_oe, busy, done}, 4'b0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 190000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done, "R1", "in reset",
              {mdc, mdio_oe, busy, done}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done && !ta_err, "R1", "after reset",
              {mdc, mdio_oe, busy, done}, 4'b0);
        run_txn(1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 1'b0, 1'b0);  // R9 write
        run_txn(1'b1, 5'h01, 5'h1E, 16'h0,    16'h8001, 1'b0, 1'b0);  // R8 good read
        run_txn(1'b1, 5'h12, 5'h0D, 16'h0,    16'hFFFF, 1'b1, 1'b0);  // R7 missing turnaround
        run_txn(1'b0, 5'h0A, 5'h15, 16'hFFFF, 16'h0, 1'b0, 1'b1);  // R10 disturbed write
        run_txn(1'b1, 5'h15, 5'h0A, 16'h0,    16'h7FFE, 1'b0, 1'b1);  // R10 disturbed read
        run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1'b0, 1'b0);  // R4 address extremes
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule